// File: doc/BRIEF.md
# Shared Scratch Flag Register Bank

This block holds a small set of 32-bit flag words that two agents, such as a host processor and a management controller, use to pass status bits to each other. It sits on a simple single-cycle register-access bus with 64-bit data. Each flag word appears at three adjacent word addresses, and each address gives a different kind of access:

- a plain view that can be read and written;
- a write-only view that clears the bits written as 1;
- a write-only view that sets the bits written as 1.

Because of the clear and set views, either agent can change single bits without a read-modify-write sequence that could race with the other agent.

The block decodes the word address into a register index and a view type. It then updates storage or returns read data one cycle later. It flags two kinds of bad access:

- a read of a write-only view gives zero data and an error pulse;
- an access outside the window changes nothing and gives an unmapped pulse.

Top module: `scratch_flag_bank`

## Requirements
- R1: The window spans word addresses 0x60AC to 0x60C3 inclusive. With rel = addr − 0x60AC, the flag index is rel / 3 and the view type is rel mod 3. Index 0 is at the base of the window and index 7 ends at 0x60C3.
- R2: A write at view type 0 replaces the whole flag word with wdata[31:0]. A read issued in the next cycle sees the new value.
- R3: A read at view type 0 raises rvalid in the cycle after the request. rdata holds the flag word in bits [31:0] and zeros in bits [63:32], and err stays low.
- R4: A write at view type 1 changes the flag word to word AND NOT wdata[31:0]. Only bits written as 1 are cleared.
- R5: A write at view type 2 changes the flag word to word OR wdata[31:0]. Only bits written as 1 are set.
- R6: A read at view type 1 or 2 raises rvalid with rdata all zero, together with a one-cycle err pulse, in the cycle after the request.
- R7: A write of any view type raises none of rvalid, err or unmapped.
- R8: An access outside the window changes no flag word. It raises unmapped for one cycle in the cycle after the request, with err low and rdata zero. A read outside the window also raises rvalid.
- R9: A synchronous active-high reset clears all eight flag words and drives rvalid, rdata, err and unmapped low.
- R10: While req is low, no flag word changes and no output is raised, whatever we, addr and wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 64 | Write data; only bits [31:0] are stored |
| rdata | output | 64 | Read data, zero-extended |
| rvalid | output | 1 | Read response valid, one cycle after a read request |
| err | output | 1 | Read of a write-only view |
| unmapped | output | 1 | Access outside the flag window |

## Verification
The bench builds the block with its default parameters: eight flag words, 32-bit storage, a 64-bit bus and a base address of 0x60AC. With these values, every view of every index can be reached, including:

- the last address of the window, 0x60C3;
- the addresses just below and just above the window;
- data whose upper 32 bits are non-zero, which shows the truncation on write and the zero-extension on read.

A reference array of eight words predicts every response. The bench issues clear and set on the same word back to back and reads the word straight after. It also checks that reset clears words written earlier in the run.

// File: rtl/flag_bank_pkg.sv
package flag_bank_pkg;

  // View type encoded by (addr - base) mod 3
  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_CLEAR = 2'd1,
    VIEW_SET   = 2'd2
  } view_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPlain;
    logic wrClear;
    logic wrSet;
    logic rdPlain;
    logic rdIllegal;
    logic rdOutside;
    logic outside;
  } strobe_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h60AC,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned WIN      = NUM_REGS * 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  idx,
  output logic              err,
  output logic              unmapped
);

  localparam logic [ADDR_W-1:0] THREE  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] WIN_SZ = ADDR_W'(WIN);

  logic [ADDR_W-1:0] relOff;
  logic              inWin;
  view_e             view;

  always_comb begin
    relOff = addr - BASE_ADDR;
    inWin  = (addr >= BASE_ADDR) && (relOff < WIN_SZ);
    idx    = IDX_W'(relOff / THREE);
    view   = view_e'(2'(relOff % THREE));
  end

  always_comb begin
    strb           = '0;
    strb.outside   = req && !inWin;
    strb.rdOutside = req && !inWin && !we;
    if (req && inWin) begin
      if (we) begin
        strb.wrPlain = (view == VIEW_PLAIN);
        strb.wrClear = (view == VIEW_CLEAR);
        strb.wrSet   = (view == VIEW_SET);
      end else begin
        strb.rdPlain   = (view == VIEW_PLAIN);
        strb.rdIllegal = (view != VIEW_PLAIN);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      unmapped <= 1'b0;
    end else begin
      err      <= strb.rdIllegal;
      unmapped <= strb.outside;
    end
  end

  AST_ERR_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req && !we)); // R7
  AST_ERR_NOT_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    !(err && unmapped)); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrPlain, strb.wrClear, strb.wrSet, strb.rdPlain, strb.rdIllegal, strb.outside})); // R1

endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned BUS_W    = 64,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid
);

  logic [NUM_REGS-1:0][REG_W-1:0] flagQ;
  logic [NUM_REGS-1:0]            selVec;
  logic [REG_W-1:0]               wLow;
  logic                           anyWrite;

  assign wLow     = wdata[REG_W-1:0];
  assign anyWrite = strb.wrPlain | strb.wrClear | strb.wrSet;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlag
    assign selVec[g] = (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        flagQ[g] <= '0;
      end else if (selVec[g]) begin
        if (strb.wrPlain)      flagQ[g] <= wLow;
        else if (strb.wrClear) flagQ[g] <= flagQ[g] & ~wLow;
        else if (strb.wrSet)   flagQ[g] <= flagQ[g] | wLow;
      end
    end

    AST_PLAIN_LOADS: assert property (@(posedge clk) disable iff (rst)
      (strb.wrPlain && selVec[g]) |=> (flagQ[g] == $past(wLow))); // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (strb.wrClear && selVec[g]) |=> ((flagQ[g] & $past(wLow)) == '0)); // R4
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
      (strb.wrSet && selVec[g]) |=> ((flagQ[g] & $past(wLow)) == $past(wLow))); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= strb.rdPlain | strb.rdIllegal | strb.rdOutside;
      rdata  <= strb.rdPlain ? {{(BUS_W-REG_W){1'b0}}, flagQ[idx]} : '0;
    end
  end

  AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !anyWrite |=> $stable(flagQ)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (flagQ == '0 && !rvalid && rdata == '0)); // R9

endmodule

// File: rtl/scratch_flag_bank.sv
module scratch_flag_bank
  import flag_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned BUS_W    = 64,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h60AC,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid,
  output logic              err,
  output logic              unmapped
);

  strobe_t          strb;
  logic [IDX_W-1:0] idx;

  flag_ctrl #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .strb    (strb),
    .idx     (idx),
    .err     (err),
    .unmapped(unmapped)
  );

  flag_store #(
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W),
    .BUS_W   (BUS_W)
  ) i_store (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .idx   (idx),
    .wdata (wdata),
    .rdata (rdata),
    .rvalid(rvalid)
  );

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    err |-> (rvalid && rdata == '0)); // R6
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid); // R3
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req && we) |=> (!rvalid && !err)); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!rvalid && !err && !unmapped)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[BUS_W-1:REG_W] == '0); // R3

endmodule

// File: tb/test_scratch_flag_bank.sv
module test_scratch_flag_bank;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h60AC;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid, err, unmapped;

  typedef struct packed {
    logic        rv;
    logic [63:0] rd;
    logic        er;
    logic        um;
  } resp_t;

  resp_t       expQ[$];
  string       tagQ[$];
  logic [31:0] model [NREG];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratch_flag_bank i_scratch_flag_bank (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .err(err), .unmapped(unmapped)
  );

  // Monitor: compares one expected item per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        resp_t e;
        resp_t a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = {rvalid, rdata, err, unmapped};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s: actual rv=%0b rd=%h err=%0b um=%0b expected rv=%0b rd=%h err=%0b um=%0b",
                   t, a.rv, a.rd, a.er, a.um, e.rv, e.rd, e.er, e.um);
        end
      end
    end
  end

  task automatic step(input logic r, input logic w, input logic [15:0] a,
                      input logic [63:0] d, input string tag);
    resp_t e;
    int rel;
    int ix;
    int ty;
    @(negedge clk);
    rst = 1'b0; req = r; we = w; addr = a; wdata = d;
    e = '0;
    if (r) begin
      rel = int'(a) - int'(BASE);
      if (rel < 0 || rel >= 3*NREG) begin
        e.um = 1'b1;
        e.rv = !w;
      end else begin
        ix = rel / 3;
        ty = rel % 3;
        if (w) begin
          if (ty == 0)      model[ix] = d[31:0];
          else if (ty == 1) model[ix] = model[ix] & ~d[31:0];
          else              model[ix] = model[ix] | d[31:0];
        end else if (ty == 0) begin
          e.rv = 1'b1;
          e.rd = {32'h0, model[ix]};
        end else begin
          e.rv = 1'b1;
          e.er = 1'b1;
        end
      end
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; req = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    expQ.push_back('0);
    tagQ.push_back("R9 reset outputs");
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < NREG; i++) step(1, 0, BASE + 16'(3*i), 64'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    doReset();
    step(0, 0, 16'h0, 64'h0, "R9 idle after reset");
    readAll("R9 words zero after reset");

    // R2 / R1: plain writes with upper bus bits set
    for (int i = 0; i < NREG; i++)
      step(1, 1, BASE + 16'(3*i), {32'hDEADBEEF, 32'hA5000000 | (32'h01010101 * i)}, "R2 R7 plain write");
    readAll("R3 R1 plain read");

    // R4 clear view
    for (int i = 0; i < NREG; i++)
      step(1, 1, BASE + 16'(3*i+1), {32'hFFFFFFFF, 32'h0F0F0000 >> i}, "R4 R7 clear write");
    readAll("R4 after clear");

    // R5 set view, including last address 0x60C3
    for (int i = 0; i < NREG; i++)
      step(1, 1, BASE + 16'(3*i+2), 64'h00000000_00F000F0 << i, "R5 R7 set write");
    readAll("R5 after set");

    // Back-to-back clear then set on word 3, read right after
    step(1, 1, BASE + 16'd10, 64'hFFFFFFFF_FFFFFFFF, "R4 clear all word3");
    step(1, 1, BASE + 16'd11, 64'h00000000_80000001, "R5 set word3");
    step(1, 0, BASE + 16'd9,  64'h0, "R4 R5 back-to-back read");
    step(1, 1, BASE + 16'd11, 64'h00000000_0000FF00, "R5 set word3 again");
    step(1, 1, BASE + 16'd10, 64'h00000000_00000F01, "R4 clear word3 partial");
    step(1, 0, BASE + 16'd9,  64'h0, "R4 R5 back-to-back read 2");

    // R6 illegal reads on every write-only view
    for (int i = 0; i < NREG; i++) begin
      step(1, 0, BASE + 16'(3*i+1), 64'h0, "R6 read clear view");
      step(1, 0, BASE + 16'(3*i+2), 64'h0, "R6 read set view");
    end

    // R8 outside window
    step(1, 0, BASE - 16'd1, 64'h0, "R8 read below window");
    step(1, 0, BASE + 16'd24, 64'h0, "R8 read above window");
    step(1, 1, BASE - 16'd1, 64'hFFFFFFFF_FFFFFFFF, "R8 write below window");
    step(1, 1, BASE + 16'd24, 64'hFFFFFFFF_FFFFFFFF, "R8 write above window");
    readAll("R8 words unchanged");

    // R10 req low ignores inputs
    @(negedge clk);
    step(0, 1, BASE, 64'hFFFFFFFF_FFFFFFFF, "R10 idle with write inputs");
    step(0, 0, BASE + 16'd1, 64'h0, "R10 idle with illegal read inputs");
    step(1, 0, BASE, 64'h0, "R10 word0 unchanged");

    // R2 write then immediate read
    step(1, 1, BASE + 16'd21, 64'h12345678_CAFEF00D, "R2 write word7");
    step(1, 0, BASE + 16'd21, 64'h0, "R2 read next cycle");

    doReset();
    readAll("R9 words cleared by reset");

    repeat (3) step(0, 0, 16'h0, 64'h0, "R10 drain");
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule